// File: doc/BRIEF.md
# Adaptive Dual/Triple Lane Redundancy Supervisor

This block oversees three identical execution lanes that compute the same result stream. In normal service only two lanes are powered, and each result they both deliver is compared. A mismatch is reported as a one-cycle error pulse, which the pipeline recovery logic uses to replay the failing work. Dual operation finds errors but cannot say which lane caused them. So the block counts mismatches inside a sliding window of `WIN` cycles. When `THR` of them fall inside one window, it powers up the spare lane and switches to triple operation.

In triple operation, the spare lane first waits `SETTLE` cycles and then for a recovery-done pulse, so that its state has been brought into line with the other two. Only then does it take part in the vote. A majority vote then gives the result and names the lane that disagrees. One outvote counts as a soft error. A lane outvoted on `KHARD` consecutive votes is declared hard-failed. It is then excluded and power-gated, and the block returns to dual operation on the two healthy lanes. If all three results differ, or if the error threshold is crossed again after a lane has already been excluded, the block sets a sticky fatal flag.

Top module: `redund_ctrl`

## Requirements
- R1: After reset, lane_en is 3'b011, lane_pg is 3'b100, mode is 0 (dual), and fatal, err_pulse and res_vld are all 0.
- R2: A compare event occurs in a cycle where every lane set in lane_en has lane_vld high. In dual mode (mode 0), if the two enabled results are equal, then in the next cycle res_vld is 1 and res_out holds that value. Results from lanes that are not enabled, and cycles that are not events, have no effect on the outputs.
- R3: Every compare event whose compared results are not all equal gives err_pulse = 1 in the next cycle, for exactly that cycle. A dual-mode mismatch gives res_vld = 0.
- R4: A dual-mode mismatch in cycle c that brings the count of dual mismatches in cycles c-WIN+1..c to THR or more moves the block, at the next edge, to mode 1 with lane_pg = 3'b000. This applies only while no lane is excluded. The mismatch window is emptied at every mode change.
- R5: In mode 1 (settling), lane 2 is powered but ignored: lane_en is 3'b011, and a lane-2 value that differs from the others raises no error.
- R6: Mode 1 changes to mode 2 (triple) only on a rec_done pulse that arrives after SETTLE cycles have passed since entry. Earlier pulses are ignored. In mode 2, lane_en is 3'b111.
- R7: In mode 2, when two results agree, the next cycle shows res_out equal to the majority value with res_vld = 1. err_pulse is 1 whenever the third result differs.
- R8: In mode 2, a lane outvoted on KHARD consecutive vote events is excluded: lane_pg becomes one-hot on that lane, lane_en becomes the other two lanes, and mode becomes 0. A unanimous vote, or an outvote of another lane, restarts the count.
- R9: fatal is set when all three voted results differ, or when the R4 threshold is reached while a lane is excluded. It then stays set until reset.
- R10: After an exclusion, dual mode compares the two remaining lanes, and the excluded lane's result and valid flag have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_res | input | 3*DW | Lane results, lane i at bits [i*DW +: DW] |
| lane_vld | input | 3 | Per-lane result valid |
| rec_done | input | 1 | Pulse from recovery logic: lanes resynchronised |
| lane_en | output | 3 | Lanes whose results are currently compared |
| lane_pg | output | 3 | Power-gate request, 1 = lane switched off |
| mode | output | 2 | 0 dual, 1 settling, 2 triple |
| err_pulse | output | 1 | One-cycle pulse per mismatching compare event |
| res_out | output | DW | Agreed or majority result |
| res_vld | output | 1 | res_out updated this cycle |
| fatal | output | 1 | Sticky unrecoverable fault |

## Verification
The bench places mismatches exactly WIN-1 and WIN cycles apart. A window that is off by one cycle would then enter triple mode too early or miss the trigger. A rec_done pulse is sent while the settle counter is still running. A design that accepts it would let an unsynchronised lane vote, which shows up as an unexpected error pulse. A single outvote is followed by agreement before the real run of KHARD outvotes, so a counter that never restarts would exclude the lane too soon. The bench also crosses the threshold a second time after an exclusion and feeds three distinct results. Both must set fatal, and fatal must survive afterwards. Long random runs with a faulty lane chosen per phase are checked every cycle against a bench model.

// File: rtl/redund_pkg.sv
// Shared types for the redundancy supervisor.
// Assumes: mode encoding is visible at the top-level port and is fixed.
package redund_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL   = 2'd0,
        MODE_SETTLE = 2'd1,
        MODE_TRIPLE = 2'd2
    } mode_e;
endpackage

// File: rtl/win_count.sv
// Sliding-window mismatch counter.
// Keeps one history bit per cycle over WIN cycles. 'hit' says that the
// mismatch offered this cycle makes THR or more inside the window.
// Assumes WIN >= 2 and 1 <= THR <= WIN; clr empties the window.
module win_count #(
    parameter int WIN = 32,
    parameter int THR = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic err_in,
    output logic hit
);
    localparam int CW = $clog2(WIN + 1);

    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  cnt_q;
    logic [CW:0]    in_win;

    // errors in the last WIN-1 cycles plus the one offered now
    assign in_win = {1'b0, cnt_q} - {{CW{1'b0}}, hist_q[WIN-1]} + (CW+1)'(1);
    assign hit    = err_in && (in_win >= (CW+1)'(THR));

    // shift the history and keep the running population count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else begin
            hist_q <= {hist_q[WIN-2:0], err_in};
            cnt_q  <= cnt_q + CW'(err_in) - CW'(hist_q[WIN-1]);
        end
    end
endmodule

// File: rtl/vote_unit.sv
// Combinational compare/vote of the three lane results under a lane mask.
// A two-bit mask gives a plain equality compare. The full mask gives a
// majority vote, naming the single outvoted lane or flagging three-way
// disagreement. Assumes cmask has exactly two or three bits set.
module vote_unit #(
    parameter int DW = 16
) (
    input  logic [3*DW-1:0] res,
    input  logic [2:0]      cmask,
    output logic [DW-1:0]   maj,
    output logic            maj_ok,
    output logic            mism,
    output logic [2:0]      outv,
    output logic            all_diff
);
    logic [DW-1:0] r0, r1, r2, ra, rb;
    logic          eq01, eq02, eq12;

    assign r0   = res[0*DW +: DW];
    assign r1   = res[1*DW +: DW];
    assign r2   = res[2*DW +: DW];
    assign eq01 = (r0 == r1);
    assign eq02 = (r0 == r2);
    assign eq12 = (r1 == r2);
    assign ra   = cmask[0] ? r0 : r1;
    assign rb   = cmask[2] ? r2 : r1;

    // choose the trusted value and classify the disagreement
    always_comb begin
        maj      = ra;
        maj_ok   = 1'b0;
        mism     = 1'b0;
        outv     = 3'b000;
        all_diff = 1'b0;
        if (cmask == 3'b111) begin
            if (eq01 && eq02) begin
                maj = r0; maj_ok = 1'b1;
            end else if (eq01) begin
                maj = r0; maj_ok = 1'b1; mism = 1'b1; outv = 3'b100;
            end else if (eq02) begin
                maj = r0; maj_ok = 1'b1; mism = 1'b1; outv = 3'b010;
            end else if (eq12) begin
                maj = r1; maj_ok = 1'b1; mism = 1'b1; outv = 3'b001;
            end else begin
                mism = 1'b1; all_diff = 1'b1;
            end
        end else begin
            maj    = ra;
            maj_ok = (ra == rb);
            mism   = (ra != rb);
        end
    end
endmodule

// File: rtl/lane_health.sv
// Per-lane consecutive-outvote counters.
// A lane outvoted on KHARD vote events in a row raises 'hard' in the
// cycle of the last outvote. Any vote in which the lane is not outvoted
// restarts its run. Assumes KHARD >= 1; clr zeroes every run.
module lane_health #(
    parameter int KHARD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       vote_ev,
    input  logic [2:0] outv,
    output logic [2:0] hard
);
    localparam int HW = $clog2(KHARD + 1);

    logic [HW-1:0] run_q [3];

    for (genvar g = 0; g < 3; g++) begin : g_lane
        assign hard[g] = vote_ev && outv[g] && (run_q[g] == HW'(KHARD - 1));

        // count consecutive outvotes of this lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                run_q[g] <= '0;
            else if (vote_ev)
                run_q[g] <= outv[g] ? run_q[g] + HW'(1) : '0;
        end
    end
endmodule

// File: rtl/redund_ctrl.sv
// Adaptive dual/triple redundancy supervisor (top).
// Runs two lanes in compare mode, counts mismatches in a sliding window,
// brings up lane 2 for majority diagnosis when the window fills, then
// excludes a lane that keeps losing the vote and returns to dual mode.
// Assumes lanes 0 and 1 start as the working pair and lane 2 as spare.
module redund_ctrl
    import redund_pkg::*;
#(
    parameter int DW     = 16,
    parameter int WIN    = 32,
    parameter int THR    = 3,
    parameter int SETTLE = 6,
    parameter int KHARD  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3*DW-1:0] lane_res,
    input  logic [2:0]      lane_vld,
    input  logic            rec_done,
    output logic [2:0]      lane_en,
    output logic [2:0]      lane_pg,
    output logic [1:0]      mode,
    output logic            err_pulse,
    output logic [DW-1:0]   res_out,
    output logic            res_vld,
    output logic            fatal
);
    localparam int SW = $clog2(SETTLE + 2);

    mode_e         mode_q;
    logic [2:0]    pow_q;
    logic          excl_q;
    logic [SW-1:0] settle_q;
    logic          fatal_q;
    logic          err_q, rvld_q;
    logic [DW-1:0] res_q;

    logic [2:0]    cmask;
    logic          ev, vote_ev, win_err, win_hit, win_clr, hlth_clr;
    logic [DW-1:0] maj;
    logic          maj_ok, mism, all_diff;
    logic [2:0]    outv, hard;

    // lanes taking part in the compare for the current mode
    always_comb begin
        case (mode_q)
            MODE_SETTLE: cmask = 3'b011;
            MODE_TRIPLE: cmask = 3'b111;
            default:     cmask = pow_q;
        endcase
    end

    assign ev       = ((lane_vld & cmask) == cmask);
    assign vote_ev  = ev && (mode_q == MODE_TRIPLE);
    assign win_err  = ev && mism && (mode_q == MODE_DUAL);
    assign win_clr  = win_hit || (mode_q != MODE_DUAL);
    assign hlth_clr = (mode_q != MODE_TRIPLE) || (|hard);

    vote_unit #(.DW(DW)) u_vote (
        .res(lane_res), .cmask(cmask), .maj(maj), .maj_ok(maj_ok),
        .mism(mism), .outv(outv), .all_diff(all_diff)
    );

    win_count #(.WIN(WIN), .THR(THR)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .err_in(win_err), .hit(win_hit)
    );

    lane_health #(.KHARD(KHARD)) u_hlth (
        .clk(clk), .rst_n(rst_n), .clr(hlth_clr), .vote_ev(vote_ev),
        .outv(outv), .hard(hard)
    );

    // mode sequencing, lane power, exclusion and fatal tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_DUAL;
            pow_q    <= 3'b011;
            excl_q   <= 1'b0;
            settle_q <= '0;
            fatal_q  <= 1'b0;
        end else begin
            case (mode_q)
                MODE_DUAL: begin
                    if (win_hit) begin
                        if (!excl_q) begin
                            mode_q   <= MODE_SETTLE;
                            pow_q    <= 3'b111;
                            settle_q <= SW'(SETTLE);
                        end else begin
                            fatal_q <= 1'b1;
                        end
                    end
                end
                MODE_SETTLE: begin
                    if (settle_q == '0) begin
                        if (rec_done) mode_q <= MODE_TRIPLE;
                    end else begin
                        settle_q <= settle_q - SW'(1);
                    end
                end
                MODE_TRIPLE: begin
                    if (vote_ev && all_diff) begin
                        fatal_q <= 1'b1;
                    end else if (|hard) begin
                        pow_q  <= ~hard;
                        excl_q <= 1'b1;
                        mode_q <= MODE_DUAL;
                    end
                end
                default: mode_q <= MODE_DUAL;
            endcase
        end
    end

    // register the compare outcome towards the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            rvld_q <= 1'b0;
            res_q  <= '0;
        end else begin
            err_q  <= ev && mism;
            rvld_q <= ev && maj_ok;
            if (ev && maj_ok) res_q <= maj;
        end
    end

    assign lane_en   = cmask;
    assign lane_pg   = ~pow_q;
    assign mode      = mode_q;
    assign err_pulse = err_q;
    assign res_out   = res_q;
    assign res_vld   = rvld_q;
    assign fatal     = fatal_q;
endmodule

// File: rtl/redund_ctrl_chk.sv
// Property checker for redund_ctrl, attached by bind.
// Assumes mode encoding 0 dual, 1 settling, 2 triple.
module redund_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] lane_en,
    input logic [2:0] lane_pg,
    input logic [1:0] mode,
    input logic       fatal
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (lane_pg == 3'b100 && mode == 2'd0 && !fatal));

    assert_diag_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> (lane_pg == 3'b000));

    assert_en_not_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_en & lane_pg) == 3'b000);

    assert_settle_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (mode != 2'd0));

    assert_one_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_pg) <= 1);

    assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);
endmodule

bind redund_ctrl redund_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_pg(lane_pg),
    .mode(mode), .fatal(fatal)
);

// File: tb/redund_ctrl_bench.sv
// Bench for redund_ctrl: directed corner cases, then seeded random phases,
// all compared every cycle against a behavioural model built from the brief.
module redund_ctrl_bench;
    localparam int DW = 16, WIN = 32, THR = 3, SETTLE = 6, KHARD = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3*DW-1:0] lane_res = '0;
    logic [2:0]      lane_vld = '0;
    logic            rec_done = 1'b0;
    logic [2:0]      lane_en, lane_pg;
    logic [1:0]      mode;
    logic            err_pulse, res_vld, fatal;
    logic [DW-1:0]   res_out;

    int total = 0, bad = 0, cyc = 0;

    // model state
    logic [1:0]    m_mode;
    logic [2:0]    m_pow;
    logic          m_excl, m_fatal, m_err, m_rvld;
    int            m_settle;
    int            m_run [3];
    logic [DW-1:0] m_res;
    int            m_q[$];

    always #2 clk = ~clk;

    redund_ctrl #(.DW(DW), .WIN(WIN), .THR(THR), .SETTLE(SETTLE), .KHARD(KHARD)) u_redund_ctrl (
        .clk(clk), .rst_n(rst_n), .lane_res(lane_res), .lane_vld(lane_vld),
        .rec_done(rec_done), .lane_en(lane_en), .lane_pg(lane_pg), .mode(mode),
        .err_pulse(err_pulse), .res_out(res_out), .res_vld(res_vld), .fatal(fatal)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d act=%0h exp=%0h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [2:0] m_mask();
        if (m_mode == 2'd1) return 3'b011;
        if (m_mode == 2'd2) return 3'b111;
        return m_pow;
    endfunction

    task automatic model_reset();
        m_mode = 2'd0; m_pow = 3'b011; m_excl = 0; m_fatal = 0;
        m_err = 0; m_rvld = 0; m_settle = 0; m_res = '0;
        for (int i = 0; i < 3; i++) m_run[i] = 0;
        m_q.delete();
    endtask

    // next-cycle expectations from the current inputs, per the requirements
    task automatic model_step();
        logic [DW-1:0] r [3];
        logic [2:0] cm, ov;
        logic ev, ok, mm, ad;
        logic [DW-1:0] mj;
        int n;
        for (int i = 0; i < 3; i++) r[i] = lane_res[i*DW +: DW];
        cm = m_mask();
        ev = ((lane_vld & cm) == cm);
        ov = 3'b000; ad = 0;
        if (cm == 3'b111) begin
            if (r[0] == r[1] && r[1] == r[2]) begin mj = r[0]; ok = 1; mm = 0; end
            else if (r[0] == r[1]) begin mj = r[0]; ok = 1; mm = 1; ov = 3'b100; end
            else if (r[0] == r[2]) begin mj = r[0]; ok = 1; mm = 1; ov = 3'b010; end
            else if (r[1] == r[2]) begin mj = r[1]; ok = 1; mm = 1; ov = 3'b001; end
            else begin mj = r[0]; ok = 0; mm = 1; ad = 1; end
        end else begin
            int a, b;
            a = -1; b = -1;
            for (int i = 0; i < 3; i++) if (cm[i]) begin if (a < 0) a = i; else b = i; end
            mj = r[a]; ok = (r[a] == r[b]); mm = !ok;
        end
        m_err = ev && mm;
        m_rvld = ev && ok;
        if (ev && ok) m_res = mj;
        case (m_mode)
            2'd0: if (ev && mm) begin
                n = 1;
                foreach (m_q[i]) if (m_q[i] > cyc - WIN) n++;
                if (n >= THR) begin
                    m_q.delete();
                    if (!m_excl) begin m_mode = 2'd1; m_pow = 3'b111; m_settle = SETTLE; end
                    else m_fatal = 1;
                end else m_q.push_back(cyc);
            end
            2'd1: if (m_settle == 0) begin
                if (rec_done) m_mode = 2'd2;
            end else m_settle--;
            default: if (ev) begin
                if (ad) begin
                    m_fatal = 1;
                    for (int i = 0; i < 3; i++) m_run[i] = 0;
                end else begin
                    int hl;
                    hl = -1;
                    for (int i = 0; i < 3; i++) begin
                        m_run[i] = ov[i] ? m_run[i] + 1 : 0;
                        if (m_run[i] >= KHARD) hl = i;
                    end
                    if (hl >= 0) begin
                        m_pow = 3'b111 & ~(3'b001 << hl);
                        m_excl = 1; m_mode = 2'd0;
                        for (int i = 0; i < 3; i++) m_run[i] = 0;
                    end
                end
            end
        endcase
    endtask

    task automatic compare_all();
        chk(res_vld === m_rvld, "R2 res_vld", 32'(res_vld), 32'(m_rvld));
        if (m_rvld) chk(res_out === m_res, "R7 res_out", 32'(res_out), 32'(m_res));
        chk(err_pulse === m_err, "R3 err_pulse", 32'(err_pulse), 32'(m_err));
        chk(mode === m_mode, "R4 mode", 32'(mode), 32'(m_mode));
        chk(lane_pg === ~m_pow, "R8 lane_pg", 32'(lane_pg), 32'(~m_pow));
        chk(lane_en === m_mask(), "R6 lane_en", 32'(lane_en), 32'(m_mask()));
        chk(fatal === m_fatal, "R9 fatal", 32'(fatal), 32'(m_fatal));
    endtask

    task automatic tick(input logic [2:0] v, input logic [DW-1:0] a, b, c, input logic rd);
        lane_vld = v; lane_res = {c, b, a}; rec_done = rd;
        model_step();
        @(posedge clk); #1;
        compare_all();
        cyc++;
    endtask

    task automatic do_reset();
        rst_n = 0; lane_vld = '0; rec_done = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(lane_en == 3'b011 && lane_pg == 3'b100 && mode == 2'd0, "R1 lanes", 32'({lane_en, lane_pg, mode}), 32'({3'b011, 3'b100, 2'd0}));
        chk(!fatal && !err_pulse && !res_vld, "R1 flags", 32'({fatal, err_pulse, res_vld}), 32'd0);
        rst_n = 1;
        cyc += 3;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(3'b111, 16'h11, 16'h11, 16'h11, 0);
    endtask

    // three quick dual mismatches into settling, then wait and arm
    task automatic to_triple();
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        idle(SETTLE + 1);
        tick(3'b111, 16'h11, 16'h11, 16'h11, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rate [3];
        void'($urandom(32'd4242));
        do_reset();

        // R2: agreement passes through, lane 2 ignored in dual
        tick(3'b111, 16'h5, 16'h5, 16'h9, 0);
        chk(res_vld && res_out == 16'h5 && !err_pulse, "R2 dual agree", 32'(res_out), 32'h5);
        // R2: a missing valid means no compare event
        tick(3'b101, 16'h5, 16'h6, 16'h5, 0);
        chk(!err_pulse && !res_vld, "R2 no event", 32'({err_pulse, res_vld}), 32'd0);

        // R4: mismatches exactly WIN apart never fill the window
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        chk(err_pulse && !res_vld, "R3 dual mismatch", 32'({err_pulse, res_vld}), 32'b10);
        idle(WIN - 1);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        idle(WIN - 1);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        chk(mode == 2'd0, "R4 sparse stays dual", 32'(mode), 32'd0);

        // R4: three mismatches spanning exactly WIN cycles trip the threshold
        idle(WIN);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        idle(WIN - 3);
        tick(3'b011, 16'h1, 16'h2, 0, 0);
        chk(mode == 2'd1 && lane_pg == 3'b000, "R4 enter settle", 32'({mode, lane_pg}), 32'({2'd1, 3'b000}));

        // R5/R6: spare ignored; early rec_done ignored
        tick(3'b111, 16'h7, 16'h7, 16'h3, 1);
        chk(!err_pulse && mode == 2'd1 && lane_en == 3'b011, "R5 spare ignored", 32'({err_pulse, mode}), 32'({1'b0, 2'd1}));
        idle(SETTLE + 1);
        chk(mode == 2'd1, "R6 waits for rec_done", 32'(mode), 32'd1);
        tick(3'b111, 16'h11, 16'h11, 16'h11, 1);
        chk(mode == 2'd2 && lane_en == 3'b111, "R6 armed", 32'({mode, lane_en}), 32'({2'd2, 3'b111}));

        // R7/R8: single outvote is soft, then KHARD in a row is hard
        tick(3'b111, 16'h7, 16'h8, 16'h7, 0);
        chk(res_vld && res_out == 16'h7 && err_pulse, "R7 majority", 32'(res_out), 32'h7);
        tick(3'b111, 16'h7, 16'h7, 16'h7, 0);
        tick(3'b111, 16'h7, 16'h8, 16'h7, 0);
        tick(3'b111, 16'h7, 16'h8, 16'h7, 0);
        chk(mode == 2'd2, "R8 soft not hard", 32'(mode), 32'd2);
        tick(3'b111, 16'h7, 16'h8, 16'h7, 0);
        chk(mode == 2'd0 && lane_pg == 3'b010 && lane_en == 3'b101, "R8 exclude lane1", 32'({mode, lane_pg, lane_en}), 32'({2'd0, 3'b010, 3'b101}));

        // R10: remaining pair compared, excluded lane ignored
        tick(3'b101, 16'h4, 16'h99, 16'h4, 0);
        chk(!err_pulse && res_vld && res_out == 16'h4, "R10 pair agree", 32'(res_out), 32'h4);
        tick(3'b101, 16'h4, 16'h4, 16'h5, 0);
        chk(err_pulse, "R10 pair mismatch", 32'(err_pulse), 32'd1);

        // R9: threshold with a lane excluded is fatal and sticky
        tick(3'b101, 16'h4, 16'h4, 16'h5, 0);
        tick(3'b101, 16'h4, 16'h4, 16'h5, 0);
        chk(fatal && mode == 2'd0, "R9 second failure", 32'(fatal), 32'd1);
        idle(5);
        chk(fatal, "R9 sticky", 32'(fatal), 32'd1);

        // R9: three-way disagreement in triple mode
        do_reset();
        to_triple();
        chk(mode == 2'd2, "R6 rearmed", 32'(mode), 32'd2);
        tick(3'b111, 16'h1, 16'h2, 16'h3, 0);
        chk(fatal && err_pulse && !res_vld, "R9 all differ", 32'({fatal, err_pulse, res_vld}), 32'b110);

        // random phases, one suspect lane per phase
        for (int ph = 0; ph < 6; ph++) begin
            do_reset();
            for (int i = 0; i < 3; i++) rate[i] = 2;
            rate[ph % 3] = 25 + 10 * (ph / 3);
            for (int k = 0; k < 2500; k++) begin
                logic [DW-1:0] base, v [3];
                logic [DW-1:0] one;
                logic [2:0] vl;
                one = 1;
                base = DW'($urandom);
                for (int i = 0; i < 3; i++) begin
                    v[i] = base;
                    if ($urandom_range(99) < rate[i]) v[i] = base ^ (one << $urandom_range(DW - 1));
                    vl[i] = ($urandom_range(9) != 0);
                end
                tick(vl, v[0], v[1], v[2], $urandom_range(19) == 0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule